// File: doc/BRIEF.md
# Variable-Length Bidirectional Serial Shifter

This block is an 8-bit synchronous serial shift engine. One register holds the outgoing word and also collects the incoming bits. Software writes the word through a parallel port. It programs a bit count of 1 to 8 and picks which end of the word goes out first. A start pulse then begins the transfer. Each transfer tick, supplied by logic outside the block, drives one bit out and captures one bit in.

Because the same register both drains and fills, alignment depends on the direction. When the most significant bit goes first, a short outgoing word must sit in the upper bits, and the received bits end up in the lower bits. When the least significant bit goes first, it is the other way round. Once the programmed number of ticks has been applied, busy drops and done pulses for one cycle. Software then reads the register back through the parallel port.

Top module: `var_shift_engine`

## Requirements
- R1: After synchronous reset, busy, done, rd_data and sdo are all 0. The direction is MSB-first and the stored length code is 0, which means 8 bits.
- R2: With cfg_lsb_first=0, sdo shows bit 7 of the register. Each accepted tick shifts the register left by one, and sdi enters bit 0.
- R3: With cfg_lsb_first=1, sdo shows bit 0 of the register. Each accepted tick shifts the register right by one, and sdi enters bit 7.
- R4: An MSB-first transfer of N bits from loaded word D leaves ((D << N) mod 256) in the register. The receive bit of tick k (k = 0..N-1) is added at position N-1-k, so the last received bit lands in bit 0.
- R5: An LSB-first transfer of N bits from loaded word D leaves (D >> N) in the register. The receive bit of tick k is added at position 8-N+k, so the last received bit lands in bit 7.
- R6: A length code of 0, or any code above 8, gives an 8-bit transfer.
- R7: busy is 1 in the cycle after an accepted start. The cycle after the Nth tick shows busy=0 and done=1 together. The following cycle shows done=0.
- R8: While busy, writes to the data register (wr_en) and to the configuration (cfg_wr) have no effect on the bits sent, the bits received or the final word.
- R9: A start while busy is ignored, and the transfer still ends after its original N ticks.
- R10: While idle, xfer_tick does not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load wr_data into the shift register (idle only) |
| wr_data | input | 8 | Parallel word to transmit |
| cfg_wr | input | 1 | Load cfg_len and cfg_lsb_first (idle only) |
| cfg_len | input | 4 | Bit count code; 0 or above 8 means 8 |
| cfg_lsb_first | input | 1 | 1 = least significant bit first, 0 = most significant first |
| start | input | 1 | Begin a transfer (idle only) |
| xfer_tick | input | 1 | One-cycle transfer clock strobe |
| sdi | input | 1 | Serial data in, sampled on an accepted tick |
| sdo | output | 1 | Serial data out, the bit at the current output end |
| rd_data | output | 8 | Current contents of the shift register |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
Every result is registered once. A load, configuration write, start or tick shows its effect in the cycle after the clock edge that captures it. The bench drives each input on a falling edge, then samples at the next falling edge. By then exactly one rising edge has passed. sdo is checked before every tick, and it must equal the bit the requirements predict for that position of the loaded word. busy and done are checked in the cycle right after the last tick, and done is checked again one cycle later to confirm it is a single pulse. The final word is compared against the arithmetic formula for every length code, both directions and several data and receive patterns.

// File: rtl/vse_pkg.sv
package vse_pkg;

    typedef enum logic {
        DIR_MSB = 1'b0,
        DIR_LSB = 1'b1
    } shift_dir_e;

    localparam int unsigned VSE_DEF_W = 8;

    // Map a raw length code to the real number of bits to move.
    function automatic int unsigned vse_eff_len(input int unsigned code,
                                                input int unsigned width);
        if (code == 0 || code > width) return width;
        return code;
    endfunction

endpackage

// File: rtl/vse_cfg.sv
module vse_cfg
    import vse_pkg::*;
#(
    parameter int unsigned DATA_W = VSE_DEF_W,
    localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             busy,
    input  logic [CNT_W-1:0] len_in,
    input  logic             lsb_in,
    output logic [CNT_W-1:0] len_o,
    output shift_dir_e       dir_o
);

    logic [CNT_W-1:0] len_q;
    shift_dir_e       dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            dir_q <= DIR_MSB;
        end else if (cfg_wr && !busy) begin
            len_q <= len_in;
            dir_q <= lsb_in ? DIR_LSB : DIR_MSB;
        end
    end

    assign len_o = len_q;
    assign dir_o = dir_q;

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(len_q) && $stable(dir_q)))
        else $error("config changed during transfer");

endmodule

// File: rtl/vse_ctrl.sv
module vse_ctrl
    import vse_pkg::*;
#(
    parameter int unsigned DATA_W = VSE_DEF_W,
    localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tick,
    input  logic [CNT_W-1:0] len_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             fire_o
);

    logic [CNT_W-1:0] remain_q;
    logic             busy_q;
    logic             done_q;
    logic             fire;

    assign fire = busy_q && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    remain_q <= CNT_W'(vse_eff_len(int'(len_i), DATA_W));
                    busy_q   <= 1'b1;
                end
            end else if (fire) begin
                remain_q <= remain_q - 1'b1;
                if (remain_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign fire_o = fire;

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q)
        else $error("done while busy");

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q)
        else $error("done longer than one cycle");

    a_r9_no_reload: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tick) |=> ($stable(remain_q) && busy_q))
        else $error("count changed without a tick");

    a_r6_count_range: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (remain_q != '0 && remain_q <= CNT_W'(DATA_W)))
        else $error("remaining count out of range");

endmodule

// File: rtl/vse_shreg.sv
module vse_shreg
    import vse_pkg::*;
#(
    parameter int unsigned DATA_W = VSE_DEF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              fire,
    input  logic              sdi,
    input  shift_dir_e        dir,
    output logic [DATA_W-1:0] data_o,
    output logic              sdo
);

    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] sh_next;

    always_comb begin
        if (dir == DIR_LSB) sh_next = {sdi, sh_q[DATA_W-1:1]};
        else                sh_next = {sh_q[DATA_W-2:0], sdi};
    end

    always_ff @(posedge clk) begin
        if (rst)                 sh_q <= '0;
        else if (fire)           sh_q <= sh_next;
        else if (wr_en && !busy) sh_q <= wr_data;
    end

    assign sdo    = (dir == DIR_LSB) ? sh_q[0] : sh_q[DATA_W-1];
    assign data_o = sh_q;

    a_r2_msb_entry: assert property (@(posedge clk) disable iff (rst)
        (fire && dir == DIR_MSB) |=>
            (sh_q[0] == $past(sdi) && sh_q[DATA_W-1:1] == $past(sh_q[DATA_W-2:0])))
        else $error("MSB-first shift wrong");

    a_r3_lsb_entry: assert property (@(posedge clk) disable iff (rst)
        (fire && dir == DIR_LSB) |=>
            (sh_q[DATA_W-1] == $past(sdi) && sh_q[DATA_W-2:0] == $past(sh_q[DATA_W-1:1])))
        else $error("LSB-first shift wrong");

    a_r8_hold_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !fire) |=> $stable(sh_q))
        else $error("register changed during transfer without a tick");

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !wr_en) |=> $stable(sh_q))
        else $error("register changed while idle");

endmodule

// File: rtl/var_shift_engine.sv
module var_shift_engine
    import vse_pkg::*;
#(
    parameter int unsigned DATA_W = VSE_DEF_W,
    localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_wr,
    input  logic [CNT_W-1:0]  cfg_len,
    input  logic              cfg_lsb_first,
    input  logic              start,
    input  logic              xfer_tick,
    input  logic              sdi,
    output logic              sdo,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);

    logic [CNT_W-1:0] len_w;
    shift_dir_e       dir_w;
    logic             busy_w;
    logic             fire_w;

    vse_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_wr (cfg_wr),
        .busy   (busy_w),
        .len_in (cfg_len),
        .lsb_in (cfg_lsb_first),
        .len_o  (len_w),
        .dir_o  (dir_w)
    );

    vse_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .tick   (xfer_tick),
        .len_i  (len_w),
        .busy_o (busy_w),
        .done_o (done),
        .fire_o (fire_w)
    );

    vse_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .busy    (busy_w),
        .fire    (fire_w),
        .sdi     (sdi),
        .dir     (dir_w),
        .data_o  (rd_data),
        .sdo     (sdo)
    );

    assign busy = busy_w;

    a_r7_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_w) |=> busy_w)
        else $error("start not accepted");

endmodule

// File: tb/var_shift_engine_tb_top.sv
module var_shift_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_len = '0;
    logic       cfg_lsb_first = 1'b0;
    logic       start = 1'b0;
    logic       xfer_tick = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo;
    logic [7:0] rd_data;
    logic       busy;
    logic       done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    var_shift_engine dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_wr(cfg_wr), .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first),
        .start(start), .xfer_tick(xfer_tick), .sdi(sdi), .sdo(sdo),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] ld, input logic [3:0] code,
                        input bit lsb, input logic [7:0] rxp, input bit poke);
        int n;
        logic [7:0] exp;
        n = (code == 0 || code > 8) ? 8 : int'(code);
        @(negedge clk);
        wr_en = 1'b1; wr_data = ld;
        cfg_wr = 1'b1; cfg_len = code; cfg_lsb_first = lsb;
        @(negedge clk);
        wr_en = 1'b0; cfg_wr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({7'b0, busy}, 8'h01, "R7 busy after start");
        for (int i = 0; i < n; i++) begin
            if (poke && i == 1) begin
                // R8/R9: writes and start while busy must not matter
                wr_en = 1'b1; wr_data = ~ld; cfg_wr = 1'b1; cfg_len = 4'd1;
                cfg_lsb_first = ~lsb; start = 1'b1;
                @(negedge clk);
                wr_en = 1'b0; cfg_wr = 1'b0; start = 1'b0;
            end
            chk({7'b0, sdo}, {7'b0, (lsb ? ld[i] : ld[7-i])},
                lsb ? (poke ? "R3 R8 sdo" : "R3 sdo") : (poke ? "R2 R8 sdo" : "R2 sdo"));
            sdi = rxp[i]; xfer_tick = 1'b1;
            @(negedge clk);
            xfer_tick = 1'b0;
            if (i < n - 1) chk({7'b0, busy}, 8'h01, poke ? "R9 busy held" : "R7 busy held");
        end
        chk({6'b0, busy, done}, 8'h01, poke ? "R9 end after N" : "R7 end flags");
        if (lsb) begin
            exp = ld >> n;
            for (int k = 0; k < n; k++) exp[8-n+k] = rxp[k];
        end else begin
            exp = ld << n;
            for (int k = 0; k < n; k++) exp[n-1-k] = rxp[k];
        end
        if (code == 0 || code > 8) chk(rd_data, exp, "R6 long word");
        else if (poke)             chk(rd_data, exp, "R8 final word");
        else                       chk(rd_data, exp, lsb ? "R5 final word" : "R4 final word");
        @(negedge clk);
        chk({7'b0, done}, 8'h00, "R7 done pulse");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data, 8'h00, "R1 reset data");
        chk({6'b0, busy, done}, 8'h00, "R1 reset flags");
        chk({7'b0, sdo}, 8'h00, "R1 reset sdo");

        // R1: default length 8, MSB-first without any config write
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h81;
        @(negedge clk); wr_en = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk({7'b0, sdo}, {7'b0, wr_data[7-i]}, "R1 default MSB order");
            sdi = 1'b0; xfer_tick = 1'b1;
            @(negedge clk); xfer_tick = 1'b0;
        end
        chk({6'b0, busy, done}, 8'h01, "R1 default length 8");

        // R10: ticks while idle do nothing
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h5A;
        @(negedge clk); wr_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            sdi = 1'b1; xfer_tick = 1'b1;
            @(negedge clk); xfer_tick = 1'b0;
            chk(rd_data, 8'h5A, "R10 idle tick");
        end

        for (int d = 0; d < 2; d++) begin
            for (int c = 0; c < 16; c++) begin
                xfer(8'hA5, 4'(c), bit'(d), 8'h3C, 1'b0);
                xfer(8'hFF, 4'(c), bit'(d), 8'h00, 1'b0);
                xfer(8'h00, 4'(c), bit'(d), 8'hFF, 1'b0);
                xfer(8'h1E, 4'(c), bit'(d), 8'hC9, 1'b0);
            end
            xfer(8'hB4, 4'd5, bit'(d), 8'h6A, 1'b1);
            xfer(8'h37, 4'd8, bit'(d), 8'h91, 1'b1);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule